// File: doc/BRIEF.md
# Field-Rate Countdown with Sync Acceptance Window

This block counts half-lines (ticks at twice the line rate) and decides where each video field begins. It has two ways of working. In the standard mode the field length is fixed at 525 half-lines, and the incoming vertical sync only confirms that timing. In the nonstandard mode the field is started by the incoming sync, but only when that sync falls inside an acceptance window. A small counter of missed confirmations moves the block from the standard mode to the nonstandard one. A sync that lands exactly on count 525 moves it back.

The vertical sync input is expected to be already digitized and synchronous to `clk`. All state advances only on clock edges where `hl_en` is high. A select input picks one of two window placements. The block produces four outputs: a one-clock field-start strobe that launches vertical blanking and sweep, a vertical drive pulse, the mode flag, and a window-active flag.

Top module: `vsync_countdown`

## Requirements
- R1: Synchronous reset clears the half-line counter to 0, selects nonstandard mode and drives `field_start` and `vdrive` low. Every field restart reloads the counter to 1, so count n is the n-th tick of the field.
- R2: `win_active` is high exactly while the counter lies in [464, 592] with `win_sel` = 0, or in [512, 568] with `win_sel` = 1, bounds included.
- R3: In standard mode the field restarts on the tick where the counter reads 525, whether or not a sync edge arrives, giving a period of 525 ticks.
- R4: In standard mode, each restart with no sync edge at count 525 adds one to a 3-bit miss count, and a coincident edge clears it. The eighth consecutive miss switches to nonstandard mode at that restart.
- R5: In nonstandard mode, a sync rising edge on a tick where the counter is inside the window restarts the field on that tick.
- R6: In nonstandard mode with no accepted edge, the field restarts on the tick where the counter has reached the window-close count or beyond: a period of 592 (`win_sel` = 0) or 568 (`win_sel` = 1).
- R7: In nonstandard mode, an accepted sync edge at count 525 selects standard mode with the miss count at zero.
- R8: Sync edges outside the window never restart the field. In standard mode, edges at any count other than 525 are also ignored and are scored as misses.
- R9: Sync is sampled once per tick and only a low-to-high change between consecutive ticks counts as an edge. A pulse lasting many ticks triggers at most once, and a pulse that rises before the window opens is never accepted.
- R10: `field_start` is high for exactly the one clock after each restart tick.
- R11: `vdrive` is high while the counter reads 1 to 16 after at least one restart, i.e. 16 ticks starting at each field restart. It stays low before the first restart.
- R12: On clocks with `hl_en` low, no state changes and `field_start` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hl_en | input | 1 | Half-line tick enable (twice the line rate) |
| vsync_in | input | 1 | Synchronized vertical sync, active high |
| win_sel | input | 1 | Window select: 0 = wide window, 1 = narrow window |
| field_start | output | 1 | One-clock strobe after each field restart |
| vdrive | output | 1 | Vertical drive pulse, 16 ticks long |
| std_mode | output | 1 | 1 = fixed 525 mode, 0 = windowed sync mode |
| win_active | output | 1 | Counter is inside the acceptance window |

## Verification
The hardest case to reach from the ports is the miss count sitting just below its limit after it has been cleared part way. Reaching it takes hundreds of ticks of exact sync placement. The stimulus places each sync pulse at a chosen count of the bench's own half-line tally. It runs three standard fields with the sync off its mark, then one field with a coincident sync, then seven silent fields, and checks that the mode still holds. One more silent field must then drop it. Long sync pulses that straddle a restart, and pulses that rise just before the window opens, are placed the same way.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

  // Window open count for the chosen select value.
  function automatic int win_open_cnt(input logic sel, input int lo_open, input int hi_open);
    return sel ? hi_open : lo_open;
  endfunction

  // Window close count for the chosen select value.
  function automatic int win_close_cnt(input logic sel, input int lo_close, input int hi_close);
    return sel ? hi_close : lo_close;
  endfunction

  // Inclusive range test used for the window flag.
  function automatic logic in_range(input int val, input int first, input int last);
    return (val >= first) && (val <= last);
  endfunction

endpackage

// File: rtl/vcd_edge.sv
module vcd_edge (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sync_in,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst)       prev_q <= 1'b0;
    else if (tick) prev_q <= sync_in;
  end

  assign rise_o = tick & sync_in & ~prev_q;
endmodule

// File: rtl/vcd_counter.sv
module vcd_counter #(
  parameter int CNT_W     = 10,
  parameter int DRIVE_LEN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_o,
  output logic             vdrive_o
);
  localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(DRIVE_LEN);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= restart ? ONE : cnt_q + ONE;
      if (restart) armed_q <= 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign vdrive_o = armed_q && (cnt_q != '0) && (cnt_q <= DRV_LAST);
endmodule

// File: rtl/vcd_mode.sv
module vcd_mode #(
  parameter int MISS_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sync_rise,
  input  logic at_std,
  input  logic in_win,
  input  logic past_close,
  output logic std_o,
  output logic restart_o,
  output logic coincide_o
);
  localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

  logic [MISS_W-1:0] miss_q;
  logic              std_q;
  logic              accept;

  assign coincide_o = tick & sync_rise & at_std;
  assign accept     = sync_rise & in_win;
  assign restart_o  = tick & (std_q ? at_std : (accept | past_close));

  always_ff @(posedge clk) begin
    if (rst) begin
      miss_q <= '0;
      std_q  <= 1'b0;
    end else if (tick) begin
      if (std_q) begin
        if (at_std) begin
          if (sync_rise) begin
            miss_q <= '0;
          end else if (miss_q == MISS_MAX) begin
            miss_q <= '0;
            std_q  <= 1'b0;
          end else begin
            miss_q <= miss_q + 1'b1;
          end
        end
      end else if (accept && at_std) begin
        std_q  <= 1'b1;
        miss_q <= '0;
      end
    end
  end

  assign std_o = std_q;
endmodule

// File: rtl/vsync_countdown.sv
module vsync_countdown #(
  parameter int CNT_W     = 10,
  parameter int STD_COUNT = 525,
  parameter int OPEN_LO   = 464,
  parameter int CLOSE_LO  = 592,
  parameter int OPEN_HI   = 512,
  parameter int CLOSE_HI  = 568,
  parameter int MISS_W    = 3,
  parameter int DRIVE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic hl_en,
  input  logic vsync_in,
  input  logic win_sel,
  output logic field_start,
  output logic vdrive,
  output logic std_mode,
  output logic win_active
);
  import vcd_pkg::*;

  localparam logic [CNT_W-1:0] STD_C = CNT_W'(STD_COUNT);

  // Named internal events, visible to the checker.
  logic [CNT_W-1:0] cnt_q;
  logic             sync_rise;
  logic             restart;
  logic             coincide;
  logic             at_std;
  logic             past_close;
  logic [CNT_W-1:0] open_c;
  logic [CNT_W-1:0] close_c;
  logic             fs_q;

  assign open_c     = CNT_W'(win_open_cnt(win_sel, OPEN_LO, OPEN_HI));
  assign close_c    = CNT_W'(win_close_cnt(win_sel, CLOSE_LO, CLOSE_HI));
  assign at_std     = (cnt_q == STD_C);
  assign past_close = (cnt_q >= close_c);
  assign win_active = in_range(int'(cnt_q), int'(open_c), int'(close_c));

  vcd_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .tick   (hl_en),
    .sync_in(vsync_in),
    .rise_o (sync_rise)
  );

  vcd_mode #(.MISS_W(MISS_W)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .tick      (hl_en),
    .sync_rise (sync_rise),
    .at_std    (at_std),
    .in_win    (win_active),
    .past_close(past_close),
    .std_o     (std_mode),
    .restart_o (restart),
    .coincide_o(coincide)
  );

  vcd_counter #(.CNT_W(CNT_W), .DRIVE_LEN(DRIVE_LEN)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (hl_en),
    .restart (restart),
    .cnt_o   (cnt_q),
    .vdrive_o(vdrive)
  );

  always_ff @(posedge clk) begin
    if (rst) fs_q <= 1'b0;
    else     fs_q <= restart;
  end

  assign field_start = fs_q;
endmodule

// File: rtl/vcd_checker.sv
module vcd_checker #(
  parameter int CNT_W     = 10,
  parameter int STD_COUNT = 525
) (
  input logic             clk,
  input logic             rst,
  input logic             hl_en,
  input logic             field_start,
  input logic             vdrive,
  input logic             std_mode,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] STD_C = CNT_W'(STD_COUNT);

  AST_FS_SINGLE:  assert property (@(posedge clk) disable iff (rst) field_start |=> !field_start);          // R10
  AST_FS_RELOAD:  assert property (@(posedge clk) disable iff (rst) field_start |-> (cnt == CNT_W'(1)));  // R1
  AST_IDLE_HOLD:  assert property (@(posedge clk) disable iff (rst) !hl_en |=> $stable(cnt));              // R12
  AST_STD_BOUND:  assert property (@(posedge clk) disable iff (rst) std_mode |-> (cnt <= STD_C));          // R3
  AST_VD_START:   assert property (@(posedge clk) disable iff (rst) $rose(vdrive) |-> field_start);        // R11
  AST_MODE_DROP:  assert property (@(posedge clk) disable iff (rst) $fell(std_mode) |-> field_start);      // R4
  AST_MODE_RISE:  assert property (@(posedge clk) disable iff (rst) $rose(std_mode) |-> field_start);      // R7
endmodule

bind vsync_countdown vcd_checker #(.CNT_W(CNT_W), .STD_COUNT(STD_COUNT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hl_en      (hl_en),
  .field_start(field_start),
  .vdrive     (vdrive),
  .std_mode   (std_mode),
  .cnt        (cnt_q)
);

// File: tb/vsync_countdown_tb.sv
module vsync_countdown_tb;
  logic clk = 1'b0;
  logic rst, hl_en, vsync_in, win_sel;
  logic field_start, vdrive, std_mode, win_active;

  always #10 clk = ~clk;

  vsync_countdown u_dut (
    .clk(clk), .rst(rst), .hl_en(hl_en), .vsync_in(vsync_in), .win_sel(win_sel),
    .field_start(field_start), .vdrive(vdrive), .std_mode(std_mode), .win_active(win_active)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  // Bench reference state, in half-line ticks.
  int m_cnt, m_miss, m_prev, m_armed, m_std;
  int tick_no = 0, last_fs = 0, n_fs = 0, last_period = 0;
  int plen_left = 0;

  function automatic int w_first(input logic s); return s ? 512 : 464; endfunction
  function automatic int w_last(input logic s);  return s ? 568 : 592; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (tick %0d)", req, act, exp, tick_no);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_tick(input logic vs);
    int c, fst, lst;
    bit e, inw, rs;
    logic win_keep;
    @(negedge clk);
    vsync_in = vs; hl_en = 1'b1;
    @(negedge clk);
    hl_en = 1'b0;
    tick_no++;
    c = m_cnt; fst = w_first(win_sel); lst = w_last(win_sel);
    e = vs && (m_prev == 0);
    inw = (c >= fst) && (c <= lst);
    if (m_std != 0) begin
      rs = (c == 525);
      if (c == 525) begin
        if (e) m_miss = 0;
        else if (m_miss == 7) begin m_miss = 0; m_std = 0; end
        else m_miss++;
      end
    end else begin
      rs = (e && inw) || (c >= lst);
      if (e && inw && c == 525) begin m_std = 1; m_miss = 0; end
    end
    m_cnt = rs ? 1 : c + 1;
    m_prev = vs ? 1 : 0;
    if (rs) m_armed = 1;
    check(field_start == rs, "R10 field_start", field_start, rs);
    check(vdrive == (m_armed != 0 && m_cnt >= 1 && m_cnt <= 16), "R11 vdrive", vdrive,
          (m_armed != 0 && m_cnt >= 1 && m_cnt <= 16));
    check(win_active == (m_cnt >= fst && m_cnt <= lst), "R2 win_active", win_active,
          (m_cnt >= fst && m_cnt <= lst));
    check(std_mode == (m_std != 0), "R4 std_mode", std_mode, m_std);
    if (field_start) begin
      if (n_fs > 0) last_period = tick_no - last_fs;
      last_fs = tick_no; n_fs++;
    end
    // Idle clocks between ticks: nothing may move (R12).
    win_keep = win_active;
    for (int g = 0; g < (tick_no % 3); g++) begin
      @(negedge clk);
      check(field_start == 1'b0 && win_active == win_keep, "R12 idle hold",
            {field_start, win_active}, {1'b0, win_keep});
    end
  endtask

  // Run until nf further field starts; a sync pulse of plen ticks begins
  // on the tick where the bench tally reads sync_at (-1: none).
  task automatic run_fields(input int nf, input int sync_at, input int plen);
    int target = n_fs + nf;
    int guard = 0;
    while (n_fs < target && guard < 5000) begin
      logic vs;
      if (plen_left > 0) begin vs = 1'b1; plen_left--; end
      else if (m_cnt == sync_at) begin vs = 1'b1; plen_left = plen - 1; end
      else vs = 1'b0;
      do_tick(vs);
      guard++;
    end
    check(n_fs >= target, "R6 field restarts occurring", n_fs, target);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; hl_en = 1'b0; vsync_in = 1'b0; win_sel = 1'b0;
    m_cnt = 0; m_miss = 0; m_prev = 0; m_armed = 0; m_std = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check({field_start, vdrive, std_mode, win_active} == 4'b0000, "R1 reset outputs",
          {field_start, vdrive, std_mode, win_active}, 0);

    // R6: free run, wide then narrow window
    run_fields(3, -1, 1);
    check(last_period == 592, "R6 free-run period wide", last_period, 592);
    check(std_mode == 1'b0, "R1 starts nonstandard", std_mode, 0);
    win_sel = 1'b1;
    run_fields(3, -1, 1);
    check(last_period == 568, "R6 free-run period narrow", last_period, 568);

    // R8: edge at 500 lies before the narrow window
    run_fields(3, 500, 1);
    check(last_period == 568, "R8 edge outside narrow window", last_period, 568);

    // R5: same edge accepted by the wide window
    win_sel = 1'b0;
    run_fields(3, 500, 1);
    check(last_period == 500, "R5 sync-triggered period", last_period, 500);

    // R8: edge far outside window ignored
    run_fields(3, 100, 1);
    check(last_period == 592, "R8 early edge ignored", last_period, 592);

    // R9: long pulse inside window triggers once per field
    run_fields(3, 480, 20);
    check(last_period == 480, "R9 long pulse single trigger", last_period, 480);
    // R9: pulse rising before window opening is never accepted
    run_fields(3, 460, 20);
    check(last_period == 592, "R9 rise before window", last_period, 592);

    // R7 and R3: coincident sync enters standard mode
    run_fields(3, 525, 1);
    check(std_mode == 1'b1, "R7 enter standard", std_mode, 1);
    check(last_period == 525, "R3 standard period", last_period, 525);

    // R8/R3: off-mark syncs ignored in standard mode, scored as misses
    run_fields(3, 500, 1);
    check(last_period == 525, "R8 standard ignores off-mark", last_period, 525);
    check(std_mode == 1'b1, "R4 three misses keep mode", std_mode, 1);
    run_fields(1, 525, 1);   // clears miss count
    run_fields(7, -1, 1);
    check(std_mode == 1'b1, "R4 cleared count, seven misses", std_mode, 1);
    check(last_period == 525, "R3 period without sync", last_period, 525);
    run_fields(1, -1, 1);
    check(std_mode == 1'b0, "R4 eighth miss drops mode", std_mode, 0);
    run_fields(2, -1, 1);
    check(last_period == 592, "R6 free run after drop", last_period, 592);

    // R1: reset mid-field
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    m_cnt = 0; m_miss = 0; m_prev = 0; m_armed = 0; m_std = 0; plen_left = 0;
    @(negedge clk);
    check({vdrive, std_mode, win_active} == 3'b000, "R1 reset mid-run",
          {vdrive, std_mode, win_active}, 0);
    n_fs = 0;
    run_fields(2, -1, 1);
    check(last_period == 592, "R1 counter restarts from zero", last_period, 592);

    finish_run();
  end
endmodule